// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

The block fetches transmit descriptors from memory, four 32-bit words each, and follows their next-descriptor pointers. It streams the bytes of each frame to a MAC transmit interface and writes a completion status back into every descriptor it finishes. Software places a descriptor address in the engine with a load strobe and sets the descriptor's hardware-ownership bit. It then issues a poll demand. The engine walks the chain until it meets a descriptor it does not own, and then it waits for the next poll.

A frame sits either in one descriptor marked as both start and end, or in two chained descriptors: the first marked start, the second marked end. Transmit results arrive from the MAC side with a done strobe after the final byte. An invalid descriptor, an abort or an underflow makes the engine write back the status, drop its running flag and raise an interrupt. After that only a fresh address load brings it back.

Top module: `tx_desc_chain`

## Requirements
- R1: On a poll the engine reads the words at offsets 0, 4, 8 and 12 from the current address: status, control, buffer address, branch. Only a descriptor with status bit 31 set is processed. If bit 31 is clear, no bytes are sent and nothing is written, and the engine waits for the next poll, which re-reads the same address.
- R2: A load strobe sets the current address and the running flag (`txon_o`). A poll starts work only while `txon_o` and `enable_i` are both high. A load without a poll sends nothing.
- R3: Control bits 10:0 give the byte count. Bytes leave each buffer word lowest byte first, and the bytes past the count in the final word are never sent.
- R4: `tx_sop_o` marks the first byte of a descriptor with control bit 21, and `tx_eop_o` marks the last byte of a descriptor with bit 22. Two descriptors, the first with bits 21 and 15 and the second with bits 22 and 15, form one continuous frame.
- R5: `tx_nocrc_o` carries control bit 16 of the frame's start descriptor on every byte of that frame.
- R6: After the MAC done strobe, the status word is written with bit 31 clear. It carries the retry count in bits 3:0, bit 4 when the count is non-zero or on abort, abort in bit 8 (also in bit 15), late collision in bit 9, carrier loss in bit 10 and underflow in bit 11. A non-final descriptor is written as 0.
- R7: After a successful write-back the engine continues at the branch address, so one poll can send several frames.
- R8: A byte count of 0, a start flag where none is allowed, a missing start flag at frame begin, or a non-final descriptor without chain bit 15 all write status 0x1000 and stop the engine.
- R9: Abort, underflow or an invalid descriptor clear `txon_o`. Polls are then ignored until a new load.
- R10: `irq_o` pulses for one cycle, in the cycle after the write-back is acknowledged, when control bit 23 was set or the engine stopped.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the byte and its markers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Transmit enable |
| start_load_i | input | 1 | Load current descriptor address |
| start_addr_i | input | ADDR_W | Descriptor address to load |
| poll_i | input | 1 | Poll demand strobe |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Acknowledge, with read data |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Byte valid |
| tx_ready_i | input | 1 | MAC accepts byte |
| tx_data_o | output | 8 | Byte |
| tx_sop_o | output | 1 | First byte of frame |
| tx_eop_o | output | 1 | Last byte of frame |
| tx_nocrc_o | output | 1 | Frame without CRC append |
| tx_done_i | input | 1 | MAC result strobe |
| tx_ncr_i | input | 4 | Collision retry count |
| tx_abort_i | input | 1 | Aborted, excessive collisions |
| tx_late_i | input | 1 | Late collision |
| tx_crs_i | input | 1 | Carrier lost |
| tx_udf_i | input | 1 | FIFO underflow |
| txon_o | output | 1 | Engine running |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Memory acknowledges one cycle after a request, and the MAC model raises its done strobe three cycles after the end byte. A descriptor therefore finishes within a few dozen cycles. Every scenario waits a fixed 300 cycles after its poll and only then reads the captured byte log, the memory image, `txon_o` and the interrupt pulse count, so no check depends on the exact cycle of an event. The interrupt is counted on every cycle of the window, which also catches a pulse that is too long or duplicated. Byte order, masking and markers are compared entry by entry against patterns computed from the sweep index.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int CNT_W = 11;
  // control word fields
  localparam int C_CHAIN = 15;
  localparam int C_NOCRC = 16;
  localparam int C_SOP   = 21;
  localparam int C_EOP   = 22;
  localparam int C_IRQ   = 23;
  // status word fields
  localparam int S_OWN   = 31;
  localparam int S_COLS  = 4;
  localparam int S_ABT   = 8;
  localparam int S_LATE  = 9;
  localparam int S_CRS   = 10;
  localparam int S_UDF   = 11;
  localparam int S_BAD   = 12;
  localparam int S_XCOL  = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_BUF, ST_EMIT, ST_WAIT, ST_WB
  } eng_state_e;
endpackage

// File: rtl/tx_byte_unpack.sv
module tx_byte_unpack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic [2:0]  nbytes_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [7:0]  data_o,
  output logic        last_o
);
  logic [31:0] sh_q;
  logic [2:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= nbytes_i;
    end else if (valid_o && ready_i) begin
      sh_q  <= {8'h00, sh_q[31:8]};
      cnt_q <= cnt_q - 3'd1;
    end
  end

  assign valid_o = (cnt_q != 3'd0);
  assign data_o  = sh_q[7:0];
  assign last_o  = (cnt_q == 3'd1);

  a_r3_load_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
endmodule

// File: rtl/tx_status_pack.sv
module tx_status_pack import tx_desc_pkg::*; (
  input  logic [3:0]  ncr_i,
  input  logic        abort_i,
  input  logic        late_i,
  input  logic        crs_i,
  input  logic        udf_i,
  output logic [31:0] status_o
);
  always_comb begin
    status_o          = '0;
    status_o[3:0]     = ncr_i;
    status_o[S_COLS]  = (ncr_i != 4'd0) || abort_i;
    status_o[S_ABT]   = abort_i;
    status_o[S_XCOL]  = abort_i;
    status_o[S_LATE]  = late_i;
    status_o[S_CRS]   = crs_i;
    status_o[S_UDF]   = udf_i;
  end
endmodule

// File: rtl/tx_desc_chain.sv
module tx_desc_chain import tx_desc_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              start_load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              poll_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  output logic              tx_nocrc_o,
  input  logic              tx_done_i,
  input  logic [3:0]        tx_ncr_i,
  input  logic              tx_abort_i,
  input  logic              tx_late_i,
  input  logic              tx_crs_i,
  input  logic              tx_udf_i,
  output logic              txon_o,
  output logic              irq_o
);
  eng_state_e        state_q;
  logic [1:0]        widx_q;
  logic [ADDR_W-1:0] cur_q, buf_q, branch_q;
  logic [31:0]       ctrl_q, wb_q;
  logic [CNT_W-1:0]  remain_q;
  logic              in_frame_q, first_q, nocrc_q, stop_q, txon_q, irq_q;

  logic [31:0]       mac_status;
  logic              u_load, u_valid, u_last;
  logic [7:0]        u_data;
  logic [2:0]        u_nb;
  logic              bad_desc;
  logic [CNT_W-1:0]  cnt_w;

  assign cnt_w = ctrl_q[CNT_W-1:0];
  assign bad_desc = (cnt_w == '0)
                 || (ctrl_q[C_SOP] == in_frame_q)
                 || (!ctrl_q[C_EOP] && !ctrl_q[C_CHAIN])
                 || (in_frame_q && !ctrl_q[C_CHAIN]);

  assign u_nb   = (remain_q >= CNT_W'(4)) ? 3'd4 : remain_q[2:0];
  assign u_load = (state_q == ST_BUF) && mem_rvalid_i;

  tx_byte_unpack u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (u_load),
    .word_i  (mem_rdata_i),
    .nbytes_i(u_nb),
    .ready_i (tx_ready_i),
    .valid_o (u_valid),
    .data_o  (u_data),
    .last_o  (u_last)
  );

  tx_status_pack u_stat (
    .ncr_i   (tx_ncr_i),
    .abort_i (tx_abort_i),
    .late_i  (tx_late_i),
    .crs_i   (tx_crs_i),
    .udf_i   (tx_udf_i),
    .status_o(mac_status)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q + ADDR_W'({widx_q, 2'b00});
    mem_wdata_o = wb_q;
    case (state_q)
      ST_FETCH: mem_req_o = 1'b1;
      ST_BUF: begin
        mem_req_o  = 1'b1;
        mem_addr_o = buf_q;
      end
      ST_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = cur_q;
      end
      default: ;
    endcase
  end

  assign tx_valid_o  = u_valid;
  assign tx_data_o   = u_data;
  assign tx_sop_o    = u_valid && first_q;
  assign tx_eop_o    = u_valid && u_last && (remain_q == '0) && ctrl_q[C_EOP];
  assign tx_nocrc_o  = nocrc_q;
  assign txon_o      = txon_q;
  assign irq_o       = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      widx_q     <= '0;
      cur_q      <= '0;
      buf_q      <= '0;
      branch_q   <= '0;
      ctrl_q     <= '0;
      wb_q       <= '0;
      remain_q   <= '0;
      in_frame_q <= 1'b0;
      first_q    <= 1'b0;
      nocrc_q    <= 1'b0;
      stop_q     <= 1'b0;
      txon_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_load_i) begin
            cur_q      <= start_addr_i;
            txon_q     <= 1'b1;
            in_frame_q <= 1'b0;
          end else if (poll_i && txon_q && enable_i) begin
            widx_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_rvalid_i) begin
          widx_q <= widx_q + 2'd1;
          case (widx_q)
            2'd0: if (!mem_rdata_i[S_OWN]) state_q <= ST_IDLE;
            2'd1: ctrl_q <= mem_rdata_i;
            2'd2: buf_q <= mem_rdata_i[ADDR_W-1:0];
            default: begin
              branch_q <= mem_rdata_i[ADDR_W-1:0];
              state_q  <= ST_CHECK;
            end
          endcase
        end
        ST_CHECK: begin
          if (bad_desc) begin
            wb_q       <= 32'h1 << S_BAD;
            stop_q     <= 1'b1;
            in_frame_q <= 1'b0;
            state_q    <= ST_WB;
          end else begin
            remain_q <= cnt_w;
            if (ctrl_q[C_SOP]) begin
              first_q    <= 1'b1;
              nocrc_q    <= ctrl_q[C_NOCRC];
              in_frame_q <= 1'b1;
            end
            state_q <= ST_BUF;
          end
        end
        ST_BUF: if (mem_rvalid_i) begin
          remain_q <= remain_q - CNT_W'(u_nb);
          buf_q    <= buf_q + ADDR_W'(4);
          state_q  <= ST_EMIT;
        end
        ST_EMIT: if (u_valid && tx_ready_i) begin
          first_q <= 1'b0;
          if (u_last) begin
            if (remain_q != '0) state_q <= ST_BUF;
            else if (ctrl_q[C_EOP]) state_q <= ST_WAIT;
            else begin
              wb_q    <= '0;
              stop_q  <= 1'b0;
              state_q <= ST_WB;
            end
          end
        end
        ST_WAIT: if (tx_done_i) begin
          wb_q       <= mac_status;
          stop_q     <= tx_abort_i || tx_udf_i;
          in_frame_q <= 1'b0;
          state_q    <= ST_WB;
        end
        ST_WB: if (mem_rvalid_i) begin
          irq_q <= stop_q || ctrl_q[C_IRQ];
          if (stop_q) begin
            txon_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            cur_q   <= branch_q;
            widx_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: request held steady until acknowledged
  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r6_wb_own_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[S_OWN]);
  a_r10_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r9_stop_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txon_o) |-> irq_o);
  a_r11_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
      && $stable(tx_sop_o) && $stable(tx_eop_o));
endmodule

// File: tb/tx_desc_chain_test.sv
`timescale 1ns/1ps
module tx_desc_chain_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        enable_i = 1'b1, start_load_i = 1'b0, poll_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic        mem_req_o, mem_we_o, mem_rvalid_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        tx_valid_o, tx_sop_o, tx_eop_o, tx_nocrc_o, tx_ready_i;
  logic [7:0]  tx_data_o;
  logic        tx_done_i;
  logic [3:0]  tx_ncr_i = '0;
  logic        tx_abort_i = 0, tx_late_i = 0, tx_crs_i = 0, tx_udf_i = 0;
  logic        txon_o, irq_o;

  tx_desc_chain uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .start_load_i(start_load_i),
    .start_addr_i(start_addr_i), .poll_i(poll_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .tx_sop_o(tx_sop_o),
    .tx_eop_o(tx_eop_o), .tx_nocrc_o(tx_nocrc_o), .tx_done_i(tx_done_i),
    .tx_ncr_i(tx_ncr_i), .tx_abort_i(tx_abort_i), .tx_late_i(tx_late_i),
    .tx_crs_i(tx_crs_i), .tx_udf_i(tx_udf_i), .txon_o(txon_o), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  logic [31:0] mem [0:511];
  logic        ready_mode = 1'b0;
  int          cyc = 0;
  int          ncap = 0, irq_cnt = 0, wr_cnt = 0, mac_cnt = 0;
  logic [7:0]  cap_d [0:63];
  logic        cap_s [0:63];
  logic        cap_e [0:63];
  logic        cap_n [0:63];
  logic        finished = 1'b0;

  // memory: one-cycle acknowledge
  initial begin mem_rvalid_i = 1'b0; mem_rdata_i = '0; tx_done_i = 1'b0; end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid_i <= mem_req_o && !mem_rvalid_i;
    mem_rdata_i  <= mem[mem_addr_o[10:2]];
    if (mem_req_o && !mem_rvalid_i && mem_we_o) begin
      mem[mem_addr_o[10:2]] <= mem_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (irq_o) irq_cnt <= irq_cnt + 1;
    if (tx_valid_o && tx_ready_i && ncap < 64) begin
      cap_d[ncap] <= tx_data_o; cap_s[ncap] <= tx_sop_o;
      cap_e[ncap] <= tx_eop_o;  cap_n[ncap] <= tx_nocrc_o;
      ncap <= ncap + 1;
    end
    if (tx_valid_o && tx_ready_i && tx_eop_o) mac_cnt <= 3;
    else if (mac_cnt > 0) mac_cnt <= mac_cnt - 1;
    tx_done_i <= (mac_cnt == 1);
  end
  assign tx_ready_i = ready_mode ? cyc[0] : 1'b1;

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 29 + 5) & 255);
  endfunction

  function automatic logic [31:0] exp_stat(input int ncr, input bit ab, input bit lt,
                                           input bit cr, input bit ud);
    logic [31:0] s;
    s = 32'(ncr & 15);
    if (ncr != 0 || ab) s[4] = 1'b1;
    s[8] = ab; s[15] = ab; s[9] = lt; s[10] = cr; s[11] = ud;
    return s;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_buf(input int waddr, input int seed);
    for (int w = 0; w < 4; w++)
      mem[waddr + w] = {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)};
  endtask

  task automatic desc(input int a, input logic [31:0] st, input logic [31:0] ct,
                      input logic [31:0] bf, input logic [31:0] br);
    mem[a/4] = st; mem[a/4+1] = ct; mem[a/4+2] = bf; mem[a/4+3] = br;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    ncap = 0; irq_cnt = 0; wr_cnt = 0;
  endtask

  task automatic load(input logic [31:0] a);
    start_addr_i = a; start_load_i = 1'b1;
    @(negedge clk); start_load_i = 1'b0;
  endtask

  task automatic poll_wait();
    poll_i = 1'b1; @(negedge clk); poll_i = 1'b0;
    repeat (300) @(negedge clk);
  endtask

  // byte check: seeds give pattern of buffer 0 for first n0 bytes, then buffer 1
  task automatic chk_bytes(input string req, input int n0, input int s0,
                           input int n1, input int s1);
    int errs = 0;
    for (int i = 0; i < n0 + n1; i++) begin
      logic [7:0] e;
      e = (i < n0) ? pat(s0, i) : pat(s1, i - n0);
      if (cap_d[i] !== e) errs++;
    end
    chk(req, "byte count", 32'(ncap), 32'(n0 + n1));
    chk(req, "byte mismatches", 32'(errs), 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R2", "reset txon", {31'd0, txon_o}, 0);
    chk("R10", "reset irq", {31'd0, irq_o}, 0);
    chk("R1", "reset req", {31'd0, mem_req_o}, 0);
    chk("R3", "reset valid", {31'd0, tx_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // single-descriptor sweep: R3 R4 R5 R6 R10 R11
    for (int n = 1; n <= 9; n++) begin
      int serr = 0, eerr = 0, nerr = 0;
      bit ic, nc, lt, cr;
      clear_all();
      ic = n[0]; nc = n[1]; lt = (n == 3); cr = (n == 5);
      ready_mode = n[0];
      tx_ncr_i = 4'(n); tx_late_i = lt; tx_crs_i = cr; tx_abort_i = 0; tx_udf_i = 0;
      fill_buf(256, n);
      desc(0, 32'h8000_0000, 32'(n) | (1 << 21) | (1 << 22) | (32'(ic) << 23) | (32'(nc) << 16),
           32'h400, 32'h40);
      load(0); poll_wait();
      chk_bytes("R3 R11", n, n, 0, 0);
      for (int i = 0; i < n; i++) begin
        if (cap_s[i] !== (i == 0)) serr++;
        if (cap_e[i] !== (i == n - 1)) eerr++;
        if (cap_n[i] !== nc) nerr++;
      end
      chk("R4", "sop placement errors", 32'(serr), 0);
      chk("R4", "eop placement errors", 32'(eerr), 0);
      chk("R5", "nocrc errors", 32'(nerr), 0);
      chk("R6", "status word", mem[0], exp_stat(n, 0, lt, cr, 0));
      chk("R10", "irq count", 32'(irq_cnt), 32'(ic));
      chk("R9", "txon stays", {31'd0, txon_o}, 1);
    end
    ready_mode = 1'b0; tx_late_i = 0; tx_crs_i = 0;

    // two-descriptor frames: R4 R6
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 4; b++) begin
        int serr = 0, eerr = 0;
        clear_all();
        tx_ncr_i = 4'(a + b);
        fill_buf(256, a); fill_buf(320, b + 7);
        desc(0,  32'h8000_0000, 32'(a) | (1 << 21) | (1 << 15), 32'h400, 32'h20);
        desc(32, 32'h8000_0000, 32'(b) | (1 << 22) | (1 << 15), 32'h500, 32'h40);
        load(0); poll_wait();
        chk_bytes("R4", a, a, b, b + 7);
        for (int i = 0; i < a + b; i++) begin
          if (cap_s[i] !== (i == 0)) serr++;
          if (cap_e[i] !== (i == a + b - 1)) eerr++;
        end
        chk("R4", "split sop errors", 32'(serr), 0);
        chk("R4", "split eop errors", 32'(eerr), 0);
        chk("R6", "first desc status", mem[0], 0);
        chk("R6", "last desc status", mem[8], exp_stat(a + b, 0, 0, 0, 0));
        chk("R10", "no irq", 32'(irq_cnt), 0);
      end

    // chained frames on one poll: R7
    clear_all(); tx_ncr_i = 0;
    fill_buf(256, 3); fill_buf(320, 9);
    desc(0,  32'h8000_0000, 32'd3 | (1 << 21) | (1 << 22) | (1 << 23), 32'h400, 32'h20);
    desc(32, 32'h8000_0000, 32'd2 | (1 << 21) | (1 << 22) | (1 << 23), 32'h500, 32'h40);
    load(0); poll_wait();
    chk_bytes("R7", 3, 3, 2, 9);
    chk("R7", "second sop", {31'd0, cap_s[3]}, 1);
    chk("R7", "first eop", {31'd0, cap_e[2]}, 1);
    chk("R7", "second status", mem[8], 0);
    chk("R10", "two irqs", 32'(irq_cnt), 2);
    chk("R7", "writes", 32'(wr_cnt), 2);

    // descriptor not owned: R1
    clear_all();
    fill_buf(256, 4);
    desc(0, 32'h0, 32'd4 | (1 << 21) | (1 << 22), 32'h400, 32'h40);
    load(0); poll_wait();
    chk("R1", "no bytes when not owned", 32'(ncap), 0);
    chk("R1", "no write when not owned", 32'(wr_cnt), 0);
    chk("R1", "txon kept", {31'd0, txon_o}, 1);
    mem[0] = 32'h8000_0000;
    poll_wait();
    chk_bytes("R1", 4, 4, 0, 0);

    // enable low / load without poll: R2
    clear_all();
    fill_buf(256, 5);
    desc(0, 32'h8000_0000, 32'd2 | (1 << 21) | (1 << 22), 32'h400, 32'h40);
    load(0);
    repeat (300) @(negedge clk);
    chk("R2", "load alone sends nothing", 32'(ncap), 0);
    enable_i = 1'b0; poll_wait();
    chk("R2", "poll while disabled", 32'(ncap), 0);
    chk("R2", "status untouched", mem[0], 32'h8000_0000);
    enable_i = 1'b1; poll_wait();
    chk_bytes("R2", 2, 5, 0, 0);

    // zero count: R8 R9 R10
    clear_all();
    desc(0, 32'h8000_0000, (1 << 21) | (1 << 22), 32'h400, 32'h40);
    load(0); poll_wait();
    chk("R8", "zero count status", mem[0], 32'h1000);
    chk("R8", "zero count bytes", 32'(ncap), 0);
    chk("R9", "txon off after invalid", {31'd0, txon_o}, 0);
    chk("R10", "irq on invalid", 32'(irq_cnt), 1);
    fill_buf(256, 6);
    desc(0, 32'h8000_0000, 32'd3 | (1 << 21) | (1 << 22), 32'h400, 32'h40);
    poll_wait();
    chk("R9", "poll ignored while stopped", 32'(ncap), 0);
    load(0); poll_wait();
    chk_bytes("R9", 3, 6, 0, 0);

    // missing start flag: R8
    clear_all();
    desc(0, 32'h8000_0000, 32'd3 | (1 << 22), 32'h400, 32'h40);
    load(0); poll_wait();
    chk("R8", "no-sop status", mem[0], 32'h1000);
    chk("R8", "no-sop txon", {31'd0, txon_o}, 0);

    // abort: R6 R9
    clear_all();
    fill_buf(256, 7);
    tx_ncr_i = 4'hF; tx_abort_i = 1;
    desc(0, 32'h8000_0000, 32'd4 | (1 << 21) | (1 << 22), 32'h400, 32'h20);
    desc(32, 32'h8000_0000, 32'd4 | (1 << 21) | (1 << 22), 32'h400, 32'h40);
    load(0); poll_wait();
    chk("R6", "abort status", mem[0], exp_stat(15, 1, 0, 0, 0));
    chk("R9", "abort stops", {31'd0, txon_o}, 0);
    chk("R9", "next desc untouched", mem[8], 32'h8000_0000);
    chk("R10", "abort irq", 32'(irq_cnt), 1);

    // underflow: R6 R9
    clear_all();
    fill_buf(256, 8);
    tx_ncr_i = 0; tx_abort_i = 0; tx_udf_i = 1;
    desc(0, 32'h8000_0000, 32'd5 | (1 << 21) | (1 << 22), 32'h400, 32'h40);
    load(0); poll_wait();
    chk("R6", "underflow status", mem[0], exp_stat(0, 0, 0, 0, 1));
    chk("R9", "underflow stops", {31'd0, txon_o}, 0);
    chk("R10", "underflow irq", 32'(irq_cnt), 1);
    tx_udf_i = 0;

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule